// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a synchronous host and an external asynchronous static RAM with a 16-bit data path and byte-lane enables. The host hands over one request at a time through a valid/ready handshake. Each request carries a direction flag, a word address, write data and a byte-lane mask. The controller turns every accepted request into one complete memory cycle, with all memory strobes timed in whole system-clock periods.

Every timing count is derived at elaboration from picosecond parameters and the clock period. Each count is rounded up to whole clocks and is never less than one. The derived counts cover the address-to-data access time, the time the memory needs to release the bus, the write strobe width (which also covers the data setup time) and the hold after the write strobe.

Reads hold the output enable low for the access window and then sample the data bus. Writes keep the output enable high for the whole cycle. They wait for the bus to turn around before the write strobe falls. The controller drives data only while the write strobe is low, so it has released the bus before the memory can drive it again. Read data goes back to the host with a one-clock valid pulse.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is held and in the first idle cycle after it, the chip is deselected (`mem_sel_n`=1, `mem_sel`=0), `mem_out_en_n`=1, `mem_wr_en_n`=1, both bits of `mem_lane_en_n` are 1, `mem_data_drive`=0, `req_ready`=1 and `rsp_valid`=0.
- R2: A request is taken on a rising clock edge where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from the next cycle until the memory cycle has ended and the chip is deselected again.
- R3: For a read (`req_write`=0), the controller holds the address, chip select and `mem_out_en_n`=0 for RD_CYC cycles, starting the cycle after acceptance. It samples `mem_data_in` on the edge that closes this window. In the cycle after that edge, `rsp_valid` is 1 for exactly one cycle with the data on `rsp_rdata`, and the chip is deselected.
- R4: Mask bit i enables byte lane i (data bits 8i+7 down to 8i) and drives `mem_lane_en_n[i]` low during the cycle. On a read, a lane whose mask bit is 0 returns 0x00 in `rsp_rdata`. On a write, the memory word keeps its old value in that lane.
- R5: A write runs in four steps. First, TURN_CYC cycles with the chip selected, `mem_wr_en_n`=1, `mem_out_en_n`=1 and the bus not driven. Next, PULSE_CYC cycles with `mem_wr_en_n`=0 and the write data driven. Then HOLD_CYC cycles with `mem_wr_en_n`=1, the bus released, and the address and lane enables still held. Finally, one idle cycle with the chip deselected.
- R6: `mem_out_en_n` is 1 whenever `mem_wr_en_n` is 0. `mem_data_drive` is 1 only while `mem_wr_en_n` is 0 and the chip is selected.
- R7: While `mem_wr_en_n` stays low, `mem_addr`, `mem_data_out` and `mem_lane_en_n` do not change.
- R8: Each count equals the matching time divided by CLK_PS, rounded up, with a floor of 1. With the defaults (4000 ps clock, 10000 ps access, 5000 ps release, 7000 ps strobe, 5500 ps data setup, 0 ps hold) this gives RD_CYC=3, TURN_CYC=2, PULSE_CYC=2 and HOLD_CYC=1.
- R9: If `req_valid` stays high with a new request while a cycle is running, that request is not taken before `req_ready` returns. The controller then spends one deselected cycle before it starts the new memory cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_mask | input | DATA_W/8 | Byte-lane mask, bit i enables lane i |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | DATA_W | Read data, disabled lanes zero |
| mem_addr | output | ADDR_W | Memory address |
| mem_sel_n | output | 1 | Chip select, active low |
| mem_sel | output | 1 | Chip select, active high |
| mem_out_en_n | output | 1 | Memory output enable, active low |
| mem_wr_en_n | output | 1 | Write strobe, active low |
| mem_lane_en_n | output | DATA_W/8 | Byte-lane enables, active low |
| mem_data_out | output | DATA_W | Data toward the memory |
| mem_data_drive | output | 1 | Tristate enable for mem_data_out |
| mem_data_in | input | DATA_W | Data from the memory bus |

## Verification
Some rules hold on every cycle, and the assertions check those. They cover the strobe rules: the write strobe only with the chip selected and its output enable off, bus drive only under the write strobe, and address, data and lanes frozen while the strobe is low. They also check that the strobe width and turnaround count are never short, that ready stays low while the chip is selected, and that the response is a single pulse. Other properties only show up in the bench's scenarios against a memory model that returns garbage until the access time has passed: the exact per-cycle profile of each operation, the sampling edge, lane masking of read and write data, the derived counts, and the behaviour of a request held through a busy cycle.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        PH_IDLE     = 3'd0,
        PH_RD_WAIT  = 3'd1,
        PH_WR_TURN  = 3'd2,
        PH_WR_PULSE = 3'd3,
        PH_WR_HOLD  = 3'd4
    } phase_e;

    // Whole clock periods covering t_ps, never fewer than one.
    function automatic int unsigned ps_to_clks(input int unsigned t_ps,
                                               input int unsigned clk_ps);
        int unsigned n;
        n = (t_ps + clk_ps - 1) / clk_ps;
        if (n < 1) n = 1;
        return n;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // High in the final cycle of a window of load_val cycles.
    assign last = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
    parameter int DATA_W = 16,
    parameter int LANE_W = 8,
    localparam int LANES = DATA_W / LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [LANES-1:0]  lane_on,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] rdata,
    output logic              valid
);
    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } cap_s;

    cap_s cap_d, cap_q;
    logic [DATA_W-1:0] masked;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign masked[l*LANE_W +: LANE_W] = lane_on[l] ? bus_in[l*LANE_W +: LANE_W]
                                                       : '0;
    end

    always_comb begin
        cap_d       = cap_q;
        cap_d.valid = capture;
        if (capture) cap_d.data = masked;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign rdata = cap_q.data;
    assign valid = cap_q.valid;
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W        = 20,
    parameter int DATA_W        = 16,
    parameter int CLK_PS        = 4000,
    parameter int T_ACCESS_PS   = 10000,
    parameter int T_RELEASE_PS  = 5000,
    parameter int T_STROBE_PS   = 7000,
    parameter int T_DSETUP_PS   = 5500,
    parameter int T_WHOLD_PS    = 0,
    localparam int LANE_W       = 8,
    localparam int LANES        = DATA_W / LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_mask,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_sel_n,
    output logic              mem_sel,
    output logic              mem_out_en_n,
    output logic              mem_wr_en_n,
    output logic [LANES-1:0]  mem_lane_en_n,
    output logic [DATA_W-1:0] mem_data_out,
    output logic              mem_data_drive,
    input  logic [DATA_W-1:0] mem_data_in
);
    localparam int RD_CYC    = ps_to_clks(T_ACCESS_PS, CLK_PS);
    localparam int TURN_CYC  = ps_to_clks(T_RELEASE_PS, CLK_PS);
    localparam int PULSE_CYC = max2(ps_to_clks(T_STROBE_PS, CLK_PS),
                                    ps_to_clks(T_DSETUP_PS, CLK_PS));
    localparam int HOLD_CYC  = ps_to_clks(T_WHOLD_PS, CLK_PS);
    localparam int MAX_CYC   = max2(max2(RD_CYC, TURN_CYC), max2(PULSE_CYC, HOLD_CYC));
    localparam int CNT_W     = $clog2(MAX_CYC + 1);

    typedef struct packed {
        phase_e            phase;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [LANES-1:0]  mask;
        logic              sel;
        logic              out_en_n;
        logic              wr_en_n;
        logic [LANES-1:0]  lane_en_n;
        logic              drive;
    } ctrl_s;

    localparam ctrl_s CTRL_RESET = '{
        phase:     PH_IDLE,
        addr:      '0,
        wdata:     '0,
        mask:      '0,
        sel:       1'b0,
        out_en_n:  1'b1,
        wr_en_n:   1'b1,
        lane_en_n: '1,
        drive:     1'b0
    };

    ctrl_s            ctrl_d, ctrl_q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_last;
    logic             cap_fire;

    sram_cycle_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    sram_rd_capture #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (cap_fire),
        .lane_on (ctrl_q.mask),
        .bus_in  (mem_data_in),
        .rdata   (rsp_rdata),
        .valid   (rsp_valid)
    );

    always_comb begin
        ctrl_d   = ctrl_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        cap_fire = 1'b0;
        unique case (ctrl_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    ctrl_d.addr      = req_addr;
                    ctrl_d.wdata     = req_wdata;
                    ctrl_d.mask      = req_mask;
                    ctrl_d.sel       = 1'b1;
                    ctrl_d.lane_en_n = ~req_mask;
                    tmr_load         = 1'b1;
                    if (req_write) begin
                        ctrl_d.phase    = PH_WR_TURN;
                        ctrl_d.out_en_n = 1'b1;
                        tmr_val         = CNT_W'(TURN_CYC);
                    end else begin
                        ctrl_d.phase    = PH_RD_WAIT;
                        ctrl_d.out_en_n = 1'b0;
                        tmr_val         = CNT_W'(RD_CYC);
                    end
                end
            end
            PH_RD_WAIT: begin
                if (tmr_last) begin
                    cap_fire         = 1'b1;
                    ctrl_d.phase     = PH_IDLE;
                    ctrl_d.sel       = 1'b0;
                    ctrl_d.out_en_n  = 1'b1;
                    ctrl_d.lane_en_n = '1;
                end
            end
            PH_WR_TURN: begin
                if (tmr_last) begin
                    ctrl_d.phase   = PH_WR_PULSE;
                    ctrl_d.wr_en_n = 1'b0;
                    ctrl_d.drive   = 1'b1;
                    tmr_load       = 1'b1;
                    tmr_val        = CNT_W'(PULSE_CYC);
                end
            end
            PH_WR_PULSE: begin
                if (tmr_last) begin
                    ctrl_d.phase   = PH_WR_HOLD;
                    ctrl_d.wr_en_n = 1'b1;
                    ctrl_d.drive   = 1'b0;
                    tmr_load       = 1'b1;
                    tmr_val        = CNT_W'(HOLD_CYC);
                end
            end
            PH_WR_HOLD: begin
                if (tmr_last) begin
                    ctrl_d.phase     = PH_IDLE;
                    ctrl_d.sel       = 1'b0;
                    ctrl_d.lane_en_n = '1;
                end
            end
            default: ctrl_d = CTRL_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= CTRL_RESET;
        else        ctrl_q <= ctrl_d;
    end

    assign req_ready      = (ctrl_q.phase == PH_IDLE);
    assign mem_addr       = ctrl_q.addr;
    assign mem_sel_n      = ~ctrl_q.sel;
    assign mem_sel        = ctrl_q.sel;
    assign mem_out_en_n   = ctrl_q.out_en_n;
    assign mem_wr_en_n    = ctrl_q.wr_en_n;
    assign mem_lane_en_n  = ctrl_q.lane_en_n;
    assign mem_data_out   = ctrl_q.wdata;
    assign mem_data_drive = ctrl_q.drive;
endmodule

// File: rtl/sram_async_ctrl_chk.sv
module sram_async_ctrl_chk #(
    parameter int ADDR_W    = 20,
    parameter int DATA_W    = 16,
    parameter int LANES     = 2,
    parameter int PULSE_MIN = 2,
    parameter int TURN_MIN  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_sel_n,
    input logic              mem_sel,
    input logic              mem_out_en_n,
    input logic              mem_wr_en_n,
    input logic [LANES-1:0]  mem_lane_en_n,
    input logic [DATA_W-1:0] mem_data_out,
    input logic              mem_data_drive
);
    int unsigned low_cnt_q;
    int unsigned turn_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt_q  <= 0;
            turn_cnt_q <= 0;
        end else begin
            if (!mem_wr_en_n) low_cnt_q <= (low_cnt_q < 255) ? low_cnt_q + 1 : low_cnt_q;
            else              low_cnt_q <= 0;
            if (mem_sel && mem_out_en_n && mem_wr_en_n)
                turn_cnt_q <= (turn_cnt_q < 255) ? turn_cnt_q + 1 : turn_cnt_q;
            else
                turn_cnt_q <= 0;
        end
    end

    assert_strobe_selected_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_wr_en_n |-> (!mem_sel_n && mem_sel && mem_out_en_n));

    assert_drive_in_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_data_drive |-> (!mem_wr_en_n && mem_sel));

    assert_frozen_in_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_wr_en_n && $past(!mem_wr_en_n)) |->
            ($stable(mem_addr) && $stable(mem_data_out) && $stable(mem_lane_en_n)));

    assert_strobe_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr_en_n) |-> (low_cnt_q >= PULSE_MIN));

    assert_turnaround_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_wr_en_n) |-> (turn_cnt_q >= TURN_MIN));

    assert_busy_not_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_sel |-> !req_ready);

    assert_single_response_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .LANES     (LANES),
    .PULSE_MIN (PULSE_CYC),
    .TURN_MIN  (TURN_CYC)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_ready      (req_ready),
    .rsp_valid      (rsp_valid),
    .mem_addr       (mem_addr),
    .mem_sel_n      (mem_sel_n),
    .mem_sel        (mem_sel),
    .mem_out_en_n   (mem_out_en_n),
    .mem_wr_en_n    (mem_wr_en_n),
    .mem_lane_en_n  (mem_lane_en_n),
    .mem_data_out   (mem_data_out),
    .mem_data_drive (mem_data_drive)
);

// File: tb/sram_async_ctrl_bench.sv
module sram_async_ctrl_bench;
    localparam int AW = 20;
    localparam int DW = 16;
    // Expected counts for the default parameters (R8), worked out by hand.
    localparam int RD_N    = 3;
    localparam int TURN_N  = 2;
    localparam int PULSE_N = 2;
    localparam int HOLD_N  = 1;
    localparam int WORDS   = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [1:0]    req_mask = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic [AW-1:0] mem_addr;
    logic          mem_sel_n, mem_sel, mem_out_en_n, mem_wr_en_n, mem_data_drive;
    logic [1:0]    mem_lane_en_n;
    logic [DW-1:0] mem_data_out;
    logic [DW-1:0] mem_data_in;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [DW-1:0] model_mem [WORDS];
    logic [DW-1:0] ref_mem   [WORDS];
    int            rd_age;

    always #2 clk = ~clk;

    sram_async_ctrl u_sram_async_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_sel_n(mem_sel_n), .mem_sel(mem_sel),
        .mem_out_en_n(mem_out_en_n), .mem_wr_en_n(mem_wr_en_n),
        .mem_lane_en_n(mem_lane_en_n), .mem_data_out(mem_data_out),
        .mem_data_drive(mem_data_drive), .mem_data_in(mem_data_in)
    );

    // Memory model: data turns valid only RD_N clocks into a read.
    always @(posedge clk) begin
        if (!mem_sel_n && mem_sel && !mem_out_en_n && mem_wr_en_n) rd_age <= rd_age + 1;
        else rd_age <= 0;
        if (!mem_sel_n && mem_sel && !mem_wr_en_n && mem_data_drive) begin
            if (!mem_lane_en_n[0]) model_mem[mem_addr[5:0]][7:0]  <= mem_data_out[7:0];
            if (!mem_lane_en_n[1]) model_mem[mem_addr[5:0]][15:8] <= mem_data_out[15:8];
        end
    end
    assign mem_data_in = (rd_age >= RD_N - 1) ? model_mem[mem_addr[5:0]] : 16'hBAD0;

    function automatic logic [8:0] pins(bit rdy, bit rv, bit sel, bit oe_n, bit we_n,
                                        logic [1:0] be_n, bit drv);
        return {rdy, rv, ~sel, sel, oe_n, we_n, be_n, drv};
    endfunction

    function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [DW-1:0] nw,
                                            logic [1:0] m);
        return {m[1] ? nw[15:8] : old[15:8], m[0] ? nw[7:0] : old[7:0]};
    endfunction

    function automatic logic [DW-1:0] lanes(logic [DW-1:0] w, logic [1:0] m);
        return {m[1] ? w[15:8] : 8'h00, m[0] ? w[7:0] : 8'h00};
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_pins(string req, logic [8:0] exp, logic [AW-1:0] ea, bit ca,
                              logic [DW-1:0] ed, bit cd);
        logic [8:0] act;
        bit ok;
        act = {req_ready, rsp_valid, mem_sel_n, mem_sel, mem_out_en_n, mem_wr_en_n,
               mem_lane_en_n, mem_data_drive};
        ok = (act == exp) && (!ca || mem_addr == ea) && (!cd || mem_data_out == ed);
        check(ok, req, {act, 3'b0, mem_addr}, {exp, 3'b0, ea});
    endtask

    task automatic do_op(bit wr, logic [AW-1:0] a, logic [DW-1:0] d, logic [1:0] m);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
        @(negedge clk);
        req_valid = 1'b0;
        if (wr) begin
            for (int k = 0; k < TURN_N; k++) begin
                check_pins("R5 turn", pins(0, 0, 1, 1, 1, ~m, 0), a, 1, '0, 0);
                @(negedge clk);
            end
            for (int k = 0; k < PULSE_N; k++) begin
                check_pins("R5 R6 R8 strobe", pins(0, 0, 1, 1, 0, ~m, 1), a, 1, d, 1);
                @(negedge clk);
            end
            for (int k = 0; k < HOLD_N; k++) begin
                check_pins("R5 hold", pins(0, 0, 1, 1, 1, ~m, 0), a, 1, '0, 0);
                @(negedge clk);
            end
            check_pins("R2 R5 end", pins(1, 0, 0, 1, 1, 2'b11, 0), '0, 0, '0, 0);
            ref_mem[a[5:0]] = merge(ref_mem[a[5:0]], d, m);
        end else begin
            for (int k = 0; k < RD_N; k++) begin
                check_pins("R3 R8 access", pins(0, 0, 1, 0, 1, ~m, 0), a, 1, '0, 0);
                @(negedge clk);
            end
            check_pins("R2 R3 end", pins(1, 1, 0, 1, 1, 2'b11, 0), '0, 0, '0, 0);
            check(rsp_rdata == lanes(ref_mem[a[5:0]], m), "R4 rdata",
                  {16'h0, rsp_rdata}, {16'h0, lanes(ref_mem[a[5:0]], m)});
        end
    endtask

    task automatic finish_up();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R2 actual=hung expected=complete");
            finish_up();
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < WORDS; i++) begin
            model_mem[i] = 16'(i * 16'h0101) ^ 16'h5A3C;
            ref_mem[i]   = 16'(i * 16'h0101) ^ 16'h5A3C;
        end
        repeat (3) @(negedge clk);
        check_pins("R1 in reset", pins(1, 0, 0, 1, 1, 2'b11, 0), '0, 0, '0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_pins("R1 after reset", pins(1, 0, 0, 1, 1, 2'b11, 0), '0, 0, '0, 0);

        // Directed corner cases.
        do_op(0, 20'd5, '0, 2'b11);
        do_op(1, 20'd5, 16'hA1B2, 2'b01);   // R4: only low lane written
        do_op(0, 20'd5, '0, 2'b11);
        do_op(1, 20'd6, 16'hC3D4, 2'b10);   // R4: only high lane written
        do_op(0, 20'd6, '0, 2'b11);
        do_op(0, 20'd6, '0, 2'b00);         // R4: no lanes -> zero
        do_op(1, 20'd7, 16'hFFFF, 2'b00);   // R4: write with no lanes
        do_op(0, 20'd7, '0, 2'b11);

        // R9: request held through a busy cycle.
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 20'd9; req_mask = 2'b11;
        @(negedge clk);
        for (int k = 0; k < RD_N; k++) begin
            check_pins("R9 busy", pins(0, 0, 1, 0, 1, 2'b00, 0), 20'd9, 1, '0, 0);
            @(negedge clk);
        end
        check_pins("R9 gap", pins(1, 1, 0, 1, 1, 2'b11, 0), '0, 0, '0, 0);
        req_addr = 20'd10;
        @(negedge clk);
        req_valid = 1'b0;
        check_pins("R9 next", pins(0, 0, 1, 0, 1, 2'b00, 0), 20'd10, 1, '0, 0);
        repeat (RD_N) @(negedge clk);
        check(rsp_rdata == ref_mem[10], "R9 second rdata",
              {16'h0, rsp_rdata}, {16'h0, ref_mem[10]});

        // Random traffic.
        for (int n = 0; n < 80; n++) begin
            logic [AW-1:0] a;
            a = AW'($urandom_range(0, WORDS - 1));
            do_op(1'($urandom_range(0, 1)), a, 16'($urandom), 2'($urandom_range(0, 3)));
        end
        for (int i = 0; i < WORDS; i += 7) do_op(0, AW'(i), '0, 2'b11);

        done = 1'b1;
        finish_up();
    end
endmodule